// File: doc/BRIEF.md
# ADC-to-DAC Sample Transform Unit

This unit sits in the data path between a 10-bit converter result and an 8-bit DAC. Each accepted sample loses its two least significant bits, which leaves an 8-bit working value. One of four waveform operations is then applied to that value. The available operations are doubling, halving, inversion against full scale, and clamping between two programmable bounds.

A sample enters with a one-cycle valid strobe. The mode and the clamp bounds are captured on the same edge as the sample. The result appears on a registered output, and its own valid strobe rises exactly one clock later. Between samples the output keeps its last value, so a DAC that is wired to it holds its level.

Top module: `wave_xform`

## Requirements
- R1: The working value is the input sample with its two least significant bits dropped (in_data[9:2]). The two low bits have no effect on the result.
- R2: With mode 2'b00, the output is twice the working value. When the product exceeds 255, the output saturates at 255.
- R3: With mode 2'b01, the output is the working value shifted right by one bit, which is the quotient rounded down.
- R4: With mode 2'b10, the output is 255 minus the working value.
- R5: With mode 2'b11 and clip_lo <= clip_hi, a working value above clip_hi gives clip_hi. A working value below clip_lo gives clip_lo. Any other working value passes through unchanged.
- R6: With mode 2'b11 and clip_lo > clip_hi, the output is clip_lo for every working value.
- R7: out_valid is high in the cycle that follows each cycle in which in_valid is high, and is low otherwise. The mode and the bounds in effect are the ones present with the sample.
- R8: While in_valid is low, out_data keeps its previous value, whatever in_data, mode or the bounds do.
- R9: After reset, out_valid is 0 and out_data is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample strobe |
| in_data | input | 10 | Converter sample |
| mode | input | 2 | Operation select (00 double, 01 halve, 10 invert, 11 clip) |
| clip_lo | input | 8 | Lower clamp bound |
| clip_hi | input | 8 | Upper clamp bound |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| out_data | output | 8 | Transformed sample for the DAC |

## Verification
Every one of the 1024 input codes is sent back to back through the double, halve and invert modes. This covers the saturation knee of doubling at working value 128, odd and even codes for halving, and both ends of the inversion range. The clip mode is swept over all codes with several bound pairs: a full-range pair, a mid-range window, equal bounds, bounds at 0 and at 255, and a swapped pair. These tell apart pass-through, clamping at each side, and the handling of swapped bounds. Separate patterns check that codes which differ only in the dropped bits give the same output. They also check that input, mode and bound changes made while the strobe is low leave the output untouched.

// File: rtl/wx_pkg.sv
package wx_pkg;
  typedef enum logic [1:0] {
    WX_DOUBLE = 2'b00,
    WX_HALVE  = 2'b01,
    WX_INVERT = 2'b10,
    WX_CLIP   = 2'b11
  } wx_mode_e;

  localparam int WX_NUM_MODES = 4;
endpackage

// File: rtl/wx_reduce.sv
module wx_reduce #(
  parameter int IN_W  = 10,
  parameter int OUT_W = 8
) (
  input  logic [IN_W-1:0]  raw,
  output logic [OUT_W-1:0] work
);
  localparam int DROP = IN_W - OUT_W;

  assign work = raw[IN_W-1:DROP];

  generate
    if (DROP > 0) begin : g_low
      logic unused_low;
      assign unused_low = ^raw[DROP-1:0];
    end
  endgenerate
endmodule

// File: rtl/wx_ops.sv
module wx_ops
  import wx_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] work,
  input  logic [W-1:0] lo,
  input  logic [W-1:0] hi,
  input  wx_mode_e     mode,
  output logic [W-1:0] result,
  output logic         dbl_sat,
  output logic         bounds_swapped
);
  localparam logic [W-1:0] FULL = '1;

  function automatic logic [W-1:0] op_double(input logic [W-1:0] v);
    if (v[W-1]) return FULL;
    return {v[W-2:0], 1'b0};
  endfunction

  function automatic logic [W-1:0] op_halve(input logic [W-1:0] v);
    return {1'b0, v[W-1:1]};
  endfunction

  function automatic logic [W-1:0] op_invert(input logic [W-1:0] v);
    return FULL - v;
  endfunction

  function automatic logic [W-1:0] op_clip(input logic [W-1:0] v,
                                           input logic [W-1:0] l,
                                           input logic [W-1:0] h);
    if (l > h) return l;
    if (v > h) return h;
    if (v < l) return l;
    return v;
  endfunction

  logic [W-1:0] cand [WX_NUM_MODES];

  generate
    for (genvar g = 0; g < WX_NUM_MODES; g++) begin : g_op
      if (g == int'(WX_DOUBLE)) begin : g_dbl
        assign cand[g] = op_double(work);
      end else if (g == int'(WX_HALVE)) begin : g_hlv
        assign cand[g] = op_halve(work);
      end else if (g == int'(WX_INVERT)) begin : g_inv
        assign cand[g] = op_invert(work);
      end else begin : g_clp
        assign cand[g] = op_clip(work, lo, hi);
      end
    end
  endgenerate

  assign result         = cand[mode];
  assign dbl_sat        = work[W-1];
  assign bounds_swapped = (lo > hi);
endmodule

// File: rtl/wx_outreg.sv
module wx_outreg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic         vld,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld <= 1'b0;
      q   <= '0;
    end else begin
      vld <= load;
      if (load) q <= d;
    end
  end
endmodule

// File: rtl/wave_xform.sv
module wave_xform
  import wx_pkg::*;
#(
  parameter int IN_W  = 10,
  parameter int OUT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [IN_W-1:0]  in_data,
  input  logic [1:0]       mode,
  input  logic [OUT_W-1:0] clip_lo,
  input  logic [OUT_W-1:0] clip_hi,
  output logic             out_valid,
  output logic [OUT_W-1:0] out_data
);
  logic [OUT_W-1:0] work_val;
  logic [OUT_W-1:0] op_val;
  logic             dbl_sat;
  logic             bounds_swapped;
  wx_mode_e         mode_e;

  assign mode_e = wx_mode_e'(mode);

  wx_reduce #(.IN_W(IN_W), .OUT_W(OUT_W)) u_reduce (
    .raw  (in_data),
    .work (work_val)
  );

  wx_ops #(.W(OUT_W)) u_ops (
    .work           (work_val),
    .lo             (clip_lo),
    .hi             (clip_hi),
    .mode           (mode_e),
    .result         (op_val),
    .dbl_sat        (dbl_sat),
    .bounds_swapped (bounds_swapped)
  );

  wx_outreg #(.W(OUT_W)) u_out (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (in_valid),
    .d     (op_val),
    .vld   (out_valid),
    .q     (out_data)
  );
endmodule

// File: rtl/wave_xform_chk.sv
module wave_xform_chk #(
  parameter int IN_W  = 10,
  parameter int OUT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [1:0]       mode,
  input logic [OUT_W-1:0] clip_lo,
  input logic [OUT_W-1:0] clip_hi,
  input logic             out_valid,
  input logic [OUT_W-1:0] out_data,
  input logic [OUT_W-1:0] work_val,
  input logic             dbl_sat,
  input logic             bounds_swapped
);
  a_r7_latency: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  a_r7_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_data));

  a_r2_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == 2'b00 && dbl_sat) |=> (out_data == '1));

  a_r3_halve_top_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == 2'b01) |=> !out_data[OUT_W-1]);

  a_r4_invert_complement: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == 2'b10) |=> ((out_data ^ $past(work_val)) == '1));

  a_r5_clip_window: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == 2'b11 && !bounds_swapped)
      |=> (out_data >= $past(clip_lo) && out_data <= $past(clip_hi)));

  a_r6_swapped_low: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == 2'b11 && bounds_swapped) |=> (out_data == $past(clip_lo)));
endmodule

bind wave_xform wave_xform_chk #(.IN_W(IN_W), .OUT_W(OUT_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .in_valid       (in_valid),
  .mode           (mode),
  .clip_lo        (clip_lo),
  .clip_hi        (clip_hi),
  .out_valid      (out_valid),
  .out_data       (out_data),
  .work_val       (work_val),
  .dbl_sat        (dbl_sat),
  .bounds_swapped (bounds_swapped)
);

// File: tb/tb_wave_xform.sv
module tb_wave_xform;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       in_valid;
  logic [9:0] in_data;
  logic [1:0] mode;
  logic [7:0] clip_lo;
  logic [7:0] clip_hi;
  logic       out_valid;
  logic [7:0] out_data;

  int n_checks = 0;
  int n_fail   = 0;

  always #4 clk = ~clk;

  wave_xform dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .mode(mode), .clip_lo(clip_lo), .clip_hi(clip_hi),
    .out_valid(out_valid), .out_data(out_data)
  );

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int model(input int d, input int m, input int lo, input int hi);
    int w;
    w = d / 4;
    case (m)
      0: return (2 * w > 255) ? 255 : 2 * w;
      1: return w / 2;
      2: return 255 - w;
      default: begin
        if (lo > hi) return lo;
        if (w > hi) return hi;
        if (w < lo) return lo;
        return w;
      end
    endcase
  endfunction

  function automatic string req_of(input int m, input int lo, input int hi);
    case (m)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      default: return (lo > hi) ? "R6" : "R5";
    endcase
  endfunction

  task automatic send(input int d, input int m, input int lo, input int hi);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = 10'(d);
    mode     = 2'(m);
    clip_lo  = 8'(lo);
    clip_hi  = 8'(hi);
    @(posedge clk);
    #1;
    check("R7 out_valid", int'(out_valid), 1);
    check(req_of(m, lo, hi), int'(out_data), model(d, m, lo, hi));
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic sweep(input int m, input int lo, input int hi);
    for (int d = 0; d < 1024; d++) send(d, m, lo, hi);
    idle();
  endtask

  initial begin
    #(8 * 200000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    int held;
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0; mode = '0; clip_lo = '0; clip_hi = '0;
    repeat (3) @(posedge clk);
    #1;
    check("R9 out_valid reset", int'(out_valid), 0);
    check("R9 out_data reset", int'(out_data), 0);
    @(negedge clk);
    rst_n = 1'b1;

    sweep(0, 0, 0);
    sweep(1, 0, 0);
    sweep(2, 0, 0);
    sweep(3, 0, 255);
    sweep(3, 64, 192);
    sweep(3, 100, 100);
    sweep(3, 0, 0);
    sweep(3, 255, 255);
    sweep(3, 200, 50);

    // R1: dropped low bits have no effect
    send(10'h2A8, 1, 0, 0);
    held = int'(out_data);
    send(10'h2AB, 1, 0, 0);
    check("R1 low bits ignored", int'(out_data), held);
    send(10'h1FF, 2, 0, 0);
    check("R1 low bits ignored", int'(out_data), 255 - 127);

    // R8: changes without strobe leave output alone
    send(10'h200, 2, 0, 0);
    @(negedge clk);
    in_valid = 1'b0; in_data = 10'h3FF; mode = 2'b00; clip_lo = 8'd5; clip_hi = 8'd9;
    @(posedge clk);
    #1;
    check("R7 no strobe", int'(out_valid), 0);
    check("R8 hold", int'(out_data), 127);
    @(negedge clk);
    mode = 2'b11; in_data = 10'h000;
    @(posedge clk);
    #1;
    check("R8 hold", int'(out_data), 127);

    // R7: bounds captured with the sample
    send(10'h3FC, 3, 10, 20);
    @(negedge clk);
    in_valid = 1'b0; clip_hi = 8'd250;
    @(posedge clk);
    #1;
    check("R7 bounds with sample", int'(out_data), 20);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule